// File: doc/BRIEF.md
# Dual-Channel Quadrature Pulse Counter

This block counts transitions on two input channels into one shared signed count. Each channel brings a pulse line and a control line. All four lines first pass through a two-flop synchroniser and then through a glitch filter. The filter has a programmable width and can be bypassed. When a filtered pulse line rises or falls, a per-edge mode picks whether that edge asks for an up step, a down step or no step. The level of the channel's own filtered control line then selects a modifier. The modifier either keeps that direction, reverses it or blocks the step.

The steps that both channels request in one cycle are added and applied together, so the count moves by −2 to +2 per cycle. Software drives a clear input, which returns the count to zero, and a hold input, which freezes it. Edges that arrive while the count is held are lost. A typical use is a rotary encoder. Its A phase goes to one pulse line with the B phase as that channel's control line, and the mirror arrangement goes on the other channel.

Top module: `quad_pulse_counter`

## Requirements
- R1: With the filter enabled and threshold T ≥ 1, a synchronised level must persist for T consecutive cycles before the filter passes it. Shorter pulses are dropped. A threshold of 0 behaves like 1.
- R2: With the filter disabled, every synchronised transition is passed on, including single-cycle pulses. A pin change applied before clock edge k appears in the count after edge k+3.
- R3: Edge mode code 1 requests +1 and code 2 requests −1. Each channel has its own rising-edge mode (`rise_mode[2c+1:2c]`) and its own falling-edge mode (`fall_mode[2c+1:2c]`).
- R4: Edge mode codes 0 and 3 request no change.
- R5: The modifier `ctrl_hi_mod[2c+1:2c]` applies while channel c's filtered control line is high, and `ctrl_lo_mod[2c+1:2c]` applies while it is low. Code 0 keeps the requested direction, code 1 reverses it, and codes 2 and 3 block the step.
- R6: Steps from both channels in the same cycle are summed and applied in one update, so the count moves by −2 to +2.
- R7: `cnt_clear` forces the count to zero on the next edge. It takes priority over hold and over counting.
- R8: While `cnt_hold` is high and `cnt_clear` is low, the count keeps its value. Edges that occur during the hold are not counted later.
- R9: The count is a 16-bit two's-complement value that wraps from +32767 to −32768 and from −32768 to +32767.
- R10: While `rst` is high, the count and all internal state return to zero on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 2 | Pulse line of each channel (bit c = channel c) |
| ctrl_in | input | 2 | Control line of each channel |
| flt_en | input | 1 | 1 = glitch filter active, 0 = bypass |
| flt_thr | input | 10 | Filter width in clock cycles |
| rise_mode | input | 4 | Rising-edge mode, 2 bits per channel |
| fall_mode | input | 4 | Falling-edge mode, 2 bits per channel |
| ctrl_hi_mod | input | 4 | Modifier while control line is high, 2 bits per channel |
| ctrl_lo_mod | input | 4 | Modifier while control line is low, 2 bits per channel |
| cnt_clear | input | 1 | Clear the count to zero |
| cnt_hold | input | 1 | Freeze the count |
| count | output | 16 | Signed count, registered |

## Verification
The count accumulates, so any wrong internal state shows at the port as a wrong count, and the error persists. Some faults leave a stale filter value or a lost edge register. Others pick the wrong modifier or the wrong step sign. In each case the first miscount appears on `count` three to T+3 cycles after the offending pin change, and every later value keeps the error. For that reason the bench compares the count with a behavioural model on every clock. It also checks the hand-computed totals at the end of each pattern.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_UP    = 2'd1,
    EDGE_DOWN  = 2'd2,
    EDGE_NONE3 = 2'd3
  } edge_mode_e;

  typedef enum logic [1:0] {
    MOD_KEEP  = 2'd0,
    MOD_FLIP  = 2'd1,
    MOD_STOP  = 2'd2,
    MOD_STOP3 = 2'd3
  } ctrl_mod_e;

  // requested direction of one edge: +1, -1 or 0
  function automatic logic signed [1:0] edge_dir(input logic [1:0] mode);
    case (edge_mode_e'(mode))
      EDGE_UP:   edge_dir = 2'sd1;
      EDGE_DOWN: edge_dir = -2'sd1;
      default:   edge_dir = 2'sd0;
    endcase
  endfunction

  // apply the control-level modifier to a requested direction
  function automatic logic signed [1:0] apply_mod(input logic signed [1:0] dir,
                                                  input logic [1:0] modc);
    case (ctrl_mod_e'(modc))
      MOD_KEEP: apply_mod = dir;
      MOD_FLIP: apply_mod = -dir;
      default:  apply_mod = 2'sd0;
    endcase
  endfunction

endpackage

// File: rtl/qpc_glitch_filter.sv
module qpc_glitch_filter #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic          flt_en,
  input  logic [TW-1:0] flt_thr,
  output logic          dout
);
  localparam int RW = TW + 1;

  logic [1:0]    sync_q;
  logic [TW-1:0] run_q;
  logic          differ;
  logic          accept;
  logic [RW-1:0] run_next;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[0], din};
  end

  assign differ   = (sync_q[1] != dout);
  assign run_next = {1'b0, run_q} + RW'(1);
  assign accept   = !flt_en || (flt_thr <= TW'(1)) || (run_next >= {1'b0, flt_thr});

  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (!differ) begin
      run_q <= '0;
    end else if (accept) begin
      dout  <= sync_q[1];
      run_q <= '0;
    end else begin
      run_q <= run_q + TW'(1);
    end
  end

  // R1: the output only ever moves to the level the synchroniser held
  p_moves_to_sync_r1: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(sync_q[1])));

  // R2: in bypass the output tracks the synchroniser one cycle later
  p_bypass_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !flt_en |=> (dout == $past(sync_q[1])));

endmodule

// File: rtl/qpc_edge_step.sv
module qpc_edge_step
  import qpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_f,
  input  logic              ctrl_f,
  input  logic [1:0]        rise_mode,
  input  logic [1:0]        fall_mode,
  input  logic [1:0]        hi_mod,
  input  logic [1:0]        lo_mod,
  output logic signed [1:0] step
);
  logic              sig_d;
  logic              rise_ev;
  logic              fall_ev;
  logic signed [1:0] dir;
  logic [1:0]        modc;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= sig_f;
  end

  assign rise_ev = sig_f & ~sig_d;
  assign fall_ev = ~sig_f & sig_d;
  assign modc    = ctrl_f ? hi_mod : lo_mod;

  always_comb begin
    if (rise_ev)      dir = edge_dir(rise_mode);
    else if (fall_ev) dir = edge_dir(fall_mode);
    else              dir = 2'sd0;
    step = apply_mod(dir, modc);
  end

  // R5: a step is only ever -1, 0 or +1
  p_step_legal_r5: assert property (@(posedge clk) disable iff (rst)
    step != -2'sd2);

  // R4: an edge whose mode is code 0 or 3 requests nothing
  p_idle_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_ev && (rise_mode == 2'd0 || rise_mode == 2'd3)) |-> (step == 2'sd0));
  p_idle_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (fall_ev && (fall_mode == 2'd0 || fall_mode == 2'd3)) |-> (step == 2'sd0));

  // R3: no edge, no step
  p_no_edge_r3: assert property (@(posedge clk) disable iff (rst)
    (sig_f == sig_d) |-> (step == 2'sd0));

endmodule

// File: rtl/qpc_accum.sv
module qpc_accum #(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0][1:0]   steps,
  input  logic                  cnt_clear,
  input  logic                  cnt_hold,
  output logic signed [CW-1:0]  count
);
  logic signed [CW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int c = 0; c < NCH; c++) begin
      sum = sum + CW'($signed(steps[c]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clear) count <= '0;
    else if (!cnt_hold)   count <= count + sum;
  end

  // R6: the per-cycle change is bounded by the number of channels
  p_delta_bounded_r6: assert property (@(posedge clk) disable iff (rst)
    (sum <= CW'(NCH)) && (sum >= -CW'(NCH)));

  // R7: clear wins over hold and counting
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> (count == '0));

  // R8: hold freezes the count
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_hold && !cnt_clear) |=> $stable(count));

endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter
  import qpc_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 16,
  parameter int TW  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        pulse_in,
  input  logic [NCH-1:0]        ctrl_in,
  input  logic                  flt_en,
  input  logic [TW-1:0]         flt_thr,
  input  logic [2*NCH-1:0]      rise_mode,
  input  logic [2*NCH-1:0]      fall_mode,
  input  logic [2*NCH-1:0]      ctrl_hi_mod,
  input  logic [2*NCH-1:0]      ctrl_lo_mod,
  input  logic                  cnt_clear,
  input  logic                  cnt_hold,
  output logic signed [CW-1:0]  count
);
  logic [NCH-1:0]      sig_f;
  logic [NCH-1:0]      ctrl_f;
  logic [NCH-1:0][1:0] steps;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [1:0] step_c;

    qpc_glitch_filter #(.TW(TW)) i_flt_sig (
      .clk(clk), .rst(rst), .din(pulse_in[c]),
      .flt_en(flt_en), .flt_thr(flt_thr), .dout(sig_f[c])
    );

    qpc_glitch_filter #(.TW(TW)) i_flt_ctrl (
      .clk(clk), .rst(rst), .din(ctrl_in[c]),
      .flt_en(flt_en), .flt_thr(flt_thr), .dout(ctrl_f[c])
    );

    qpc_edge_step i_step (
      .clk(clk), .rst(rst),
      .sig_f(sig_f[c]), .ctrl_f(ctrl_f[c]),
      .rise_mode(rise_mode[2*c +: 2]), .fall_mode(fall_mode[2*c +: 2]),
      .hi_mod(ctrl_hi_mod[2*c +: 2]), .lo_mod(ctrl_lo_mod[2*c +: 2]),
      .step(step_c)
    );

    assign steps[c] = step_c;
  end

  qpc_accum #(.NCH(NCH), .CW(CW)) i_accum (
    .clk(clk), .rst(rst), .steps(steps),
    .cnt_clear(cnt_clear), .cnt_hold(cnt_hold), .count(count)
  );

  // R10: reset leaves a zero count
  p_reset_zero_r10: assert property (@(posedge clk)
    rst |=> (count == '0));

endmodule

// File: tb/test_quad_pulse_counter.sv
`timescale 1ns/1ps
module test_quad_pulse_counter;
  localparam int NCH = 2;
  localparam int CW  = 16;
  localparam int TW  = 10;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] pulse_in, ctrl_in;
  logic flt_en;
  logic [TW-1:0] flt_thr;
  logic [2*NCH-1:0] rise_mode, fall_mode, ctrl_hi_mod, ctrl_lo_mod;
  logic cnt_clear, cnt_hold;
  logic signed [CW-1:0] count;

  always #5 clk = ~clk;

  quad_pulse_counter #(.NCH(NCH), .CW(CW), .TW(TW)) i_quad_pulse_counter (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .ctrl_in(ctrl_in),
    .flt_en(flt_en), .flt_thr(flt_thr), .rise_mode(rise_mode),
    .fall_mode(fall_mode), .ctrl_hi_mod(ctrl_hi_mod), .ctrl_lo_mod(ctrl_lo_mod),
    .cnt_clear(cnt_clear), .cnt_hold(cnt_hold), .count(count)
  );

  int n_vec = 0;
  int n_fail = 0;
  string cur_req = "R10";
  bit done = 0;

  // behavioural reference: per-line sync pipe, filter run length, edge memory
  bit m_s1 [4], m_s2 [4], m_f [4];
  int m_run [4];
  bit m_sd [NCH];
  int m_count = 0;

  function automatic int dir_of(input bit [1:0] m);
    return (m == 2'd1) ? 1 : (m == 2'd2) ? -1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
      end
      for (int c = 0; c < NCH; c++) m_sd[c] = 0;
      m_count = 0;
    end else begin
      int net;
      int thr;
      net = 0;
      for (int c = 0; c < NCH; c++) begin
        int d;
        bit [1:0] md;
        d = 0;
        if (m_f[c] && !m_sd[c]) d = dir_of(rise_mode[2*c +: 2]);
        if (!m_f[c] && m_sd[c]) d = dir_of(fall_mode[2*c +: 2]);
        md = m_f[NCH + c] ? ctrl_hi_mod[2*c +: 2] : ctrl_lo_mod[2*c +: 2];
        if (md == 2'd1) d = -d;
        else if (md != 2'd0) d = 0;
        net += d;
      end
      if (cnt_clear) m_count = 0;
      else if (!cnt_hold) m_count = (m_count + net) & 16'hFFFF;
      for (int c = 0; c < NCH; c++) m_sd[c] = m_f[c];
      thr = (flt_thr == 0) ? 1 : int'(flt_thr);
      for (int i = 0; i < 4; i++) begin
        if (m_s2[i] == m_f[i]) m_run[i] = 0;
        else if (!flt_en || m_run[i] + 1 >= thr) begin
          m_f[i] = m_s2[i]; m_run[i] = 0;
        end else m_run[i]++;
      end
      for (int i = 0; i < 4; i++) begin
        m_s2[i] = m_s1[i];
        m_s1[i] = (i < NCH) ? pulse_in[i] : ctrl_in[i - NCH];
      end
    end
  end

  // compare with the model shortly after every rising edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      n_vec++;
      if (int'($unsigned(count)) != m_count) begin
        n_fail++;
        $display("FAIL %s: count=%0d expected %0d (cycle compare)",
                 cur_req, count, $signed(16'(m_count)));
      end
    end
  end

  task automatic expect_count(input int exp, input string req);
    n_vec++;
    if (count != CW'(exp)) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected %0d", req, count, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch_mask, input int w, input int g);
    @(negedge clk);
    pulse_in = pulse_in | NCH'(ch_mask);
    idle(w);
    pulse_in = pulse_in & ~NCH'(ch_mask);
    idle(g);
  endtask

  task automatic clear_cnt();
    @(negedge clk); cnt_clear = 1;
    @(negedge clk); cnt_clear = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: count=%0d expected run to end", count);
    finish_run();
  end

  initial begin
    rst = 1; pulse_in = 0; ctrl_in = 0; flt_en = 0; flt_thr = 0;
    rise_mode = 0; fall_mode = 0; ctrl_hi_mod = 0; ctrl_lo_mod = 0;
    cnt_clear = 0; cnt_hold = 0;
    idle(4);
    rst = 0;
    idle(2);
    expect_count(0, "R10");

    // R3: rising up on ch0, then falling down
    cur_req = "R3";
    rise_mode = 4'b0001;
    repeat (5) pulse(1, 3, 6);
    idle(8); expect_count(5, "R3");
    rise_mode = 4'b0000; fall_mode = 4'b0010;
    repeat (3) pulse(1, 3, 6);
    idle(8); expect_count(2, "R3");

    // R4: codes 0 and 3 do nothing
    cur_req = "R4";
    rise_mode = 4'b0011; fall_mode = 4'b1100;
    repeat (4) pulse(3, 3, 6);
    idle(8); expect_count(2, "R4");

    // R5: control-level modifiers on ch0
    cur_req = "R5";
    rise_mode = 4'b0001; fall_mode = 4'b0000;
    ctrl_hi_mod = 4'b0001; ctrl_lo_mod = 4'b0010;
    @(negedge clk); ctrl_in = 2'b01; idle(6);
    repeat (3) pulse(1, 3, 6);
    idle(8); expect_count(-1, "R5");
    ctrl_hi_mod = 4'b0010;
    repeat (2) pulse(1, 3, 6);
    idle(8); expect_count(-1, "R5");
    @(negedge clk); ctrl_in = 2'b00; idle(6);
    ctrl_lo_mod = 4'b0000;
    repeat (2) pulse(1, 3, 6);
    idle(8); expect_count(1, "R5");
    ctrl_lo_mod = 4'b0011;
    repeat (2) pulse(1, 3, 6);
    idle(8); expect_count(1, "R5");
    ctrl_lo_mod = 4'b0001;
    pulse(1, 3, 6);
    idle(8); expect_count(0, "R5");

    // R6: both channels step together
    cur_req = "R6";
    ctrl_lo_mod = 4'b0000; rise_mode = 4'b0101;
    clear_cnt();
    repeat (3) pulse(3, 3, 6);
    idle(8); expect_count(6, "R6");
    rise_mode = 4'b1001;
    repeat (2) pulse(3, 3, 6);
    idle(8); expect_count(6, "R6");

    // R2: bypass passes single-cycle pulses
    cur_req = "R2";
    rise_mode = 4'b0001;
    clear_cnt();
    repeat (4) pulse(1, 1, 4);
    idle(8); expect_count(4, "R2");

    // R1: filter width
    cur_req = "R1";
    flt_en = 1; flt_thr = 10'd4;
    clear_cnt();
    repeat (3) pulse(1, 3, 10);
    idle(10); expect_count(0, "R1");
    repeat (2) pulse(1, 4, 10);
    idle(10); expect_count(2, "R1");
    flt_thr = 10'd0;
    repeat (2) pulse(1, 1, 4);
    idle(8); expect_count(4, "R1");
    flt_en = 0;

    // R8: hold loses edges
    cur_req = "R8";
    clear_cnt();
    @(negedge clk); cnt_hold = 1;
    repeat (4) pulse(1, 3, 6);
    idle(8); expect_count(0, "R8");
    cnt_hold = 0;
    repeat (2) pulse(1, 3, 6);
    idle(8); expect_count(2, "R8");

    // R7: clear beats hold and counting
    cur_req = "R7";
    @(negedge clk); cnt_hold = 1; cnt_clear = 1; pulse_in = 2'b01;
    idle(6);
    expect_count(0, "R7");
    cnt_hold = 0; cnt_clear = 0; pulse_in = 2'b00;
    idle(8); expect_count(0, "R7");

    // R9: wrap past +32767
    cur_req = "R9";
    rise_mode = 4'b0101; fall_mode = 4'b0101;
    clear_cnt();
    for (int i = 0; i < 16400; i++) begin
      @(negedge clk); pulse_in = ~pulse_in;
    end
    idle(8); expect_count(-32736, "R9");

    idle(2);
    finish_run();
  end
endmodule